// File: doc/BRIEF.md
# Multi-Channel Event Timer Comparator

This block is a memory-mapped event timer. A 64-bit main counter advances once per clock while a global run bit is set. Several comparator channels watch the counter. Each channel can fire once, or it can fire repeatedly, adding a stored increment to its comparator after every match. Software reaches all of this over a plain 32-bit register bus with separate read and write strobes. Reads are combinational from the address. Writes take effect at the clock edge where the write strobe is high. The register bus is a control path, not a data stream, so it has no valid/ready handshake and no back-pressure.

A match sets a per-channel status bit. Software clears a status bit by writing 1 to it. Each channel drives a level or a single-cycle pulse onto one of several general interrupt lines, chosen by its route field. When the legacy-routing bit is set, channel 0 drives a dedicated system-tick line and channel 1 drives a dedicated real-time-clock line, whatever their route fields say.

Register map (byte addresses):

- 0x000: identity.
- 0x004: tick period in femtoseconds.
- 0x010: global control. Bit 0 is run. Bit 1 is legacy routing.
- 0x020: status. Bit n belongs to channel n.
- 0x0F0 / 0x0F4: counter, low half / high half.
- Channel n has its registers at 0x100 + 0x20·n:
  - +0x00: configuration.
  - +0x08: comparator, low half.
  - +0x0C: comparator, high half.

Top module: `evtimer_cmp`

## Requirements
- R1: While run (global control bit 0) is 1, the counter increases by exactly one every clock. While run is 0, the counter holds its value.
- R2: Writes to the counter halves (0x0F0 low, 0x0F4 high) load the counter only while run is 0. While run is 1, such writes are ignored.
- R3: The identity register reads as follows: bits [7:0] = 0x01, bits [12:8] = channel count minus one, bit 15 = legacy routing supported. With the defaults this is 0x8301. The period register reads PERIOD_FS. After reset, global control, status and counter all read 0.
- R4: Channel configuration bit 1 enables the channel, and only an enabled channel sets its status bit. The status bit is set one clock after the counter equals the comparator while running. In 32-bit mode (configuration bit 4 = 1) only the low 32 bits are compared. Otherwise all 64 bits are compared.
- R5: In one-shot mode (configuration bit 2 = 0), a match leaves the comparator unchanged.
- R6: In periodic mode (configuration bit 2 = 1), every match adds the stored 32-bit increment to the comparator.
- R7: Writing a configuration word with bit 3 = 1 arms a two-step sequence. The next write to the low comparator half loads the match value. The write after that loads the increment. Further writes load the comparator only. Bit 3 always reads as 0.
- R8: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R9: In level mode (configuration bit 0 = 1), the channel's interrupt follows its status bit. In pulse mode (bit 0 = 0), the channel gives a one-clock pulse per match.
- R10: A channel drives general line irq_o[route], where route is configuration bits [5+:log2(NUM_IRQ)].
- R11: When legacy routing is 1, channel 0 drives legacy_tick_o and channel 1 drives legacy_rtc_o, and neither drives its routed general line. When legacy routing is 0, both legacy outputs are low.
- R12: Clearing run stops the counter but keeps every channel's comparator value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; bus_rdata is 0 when low |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | NUM_IRQ | General routed interrupt lines |
| legacy_tick_o | output | 1 | Legacy system-tick interrupt |
| legacy_rtc_o | output | 1 | Legacy real-time-clock interrupt |

## Verification
The assertions check two things on every cycle. First, the counter steps by exactly one whenever run is set, including when a counter write lands in the same cycle. Second, a status bit never rises on a channel that was disabled, and a legacy line is never active unless legacy routing and the owning channel are both enabled. Only the directed scenarios can show the rest: the exact comparator value after a chain of periodic matches, the order of the two-step set-value writes, the count of pulses seen on a routed line, and whether 32-bit or 64-bit comparison was applied.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;
  localparam logic [11:0] A_ID     = 12'h000;
  localparam logic [11:0] A_PERIOD = 12'h004;
  localparam logic [11:0] A_GCTL   = 12'h010;
  localparam logic [11:0] A_STAT   = 12'h020;
  localparam logic [11:0] A_CNT_LO = 12'h0F0;
  localparam logic [11:0] A_CNT_HI = 12'h0F4;
  localparam logic [3:0]  CH_REGION = 4'h1;
  localparam logic [4:0]  OFF_CFG   = 5'h00;
  localparam logic [4:0]  OFF_CMPLO = 5'h08;
  localparam logic [4:0]  OFF_CMPHI = 5'h0C;

  localparam int GCTL_RUN = 0;
  localparam int GCTL_LEG = 1;

  localparam int CB_LEVEL = 0;
  localparam int CB_EN    = 1;
  localparam int CB_PER   = 2;
  localparam int CB_SETV  = 3;
  localparam int CB_M32   = 4;
  localparam int CB_ROUTE = 5;

  localparam logic [7:0] REVISION = 8'h01;

  typedef enum logic [1:0] {
    SV_IDLE,
    SV_MATCH,
    SV_INCR
  } setv_e;
endpackage

// File: rtl/evtimer_counter.sv
module evtimer_counter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic [63:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 64'd1;
    end else begin
      if (wr_lo) cnt[31:0]  <= wdata;
      if (wr_hi) cnt[63:32] <= wdata;
    end
  end
endmodule

// File: rtl/evtimer_channel.sv
module evtimer_channel
  import evtimer_pkg::*;
#(
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cmplo_wr,
  input  logic          cmphi_wr,
  input  logic [31:0]   wdata,
  input  logic [63:0]   cnt,
  input  logic          run,
  input  logic          clr,
  output logic [31:0]   cfg_rd,
  output logic [63:0]   cmp,
  output logic [RW-1:0] route,
  output logic          enabled,
  output logic          status,
  output logic          irq_raw
);
  logic        level_q, en_q, per_q, m32_q;
  logic [31:0] incr_q;
  setv_e       sv_q;
  logic        pulse_q;
  logic        hit;
  logic        match;

  assign hit   = m32_q ? (cnt[31:0] == cmp[31:0]) : (cnt == cmp);
  assign match = run && en_q && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      en_q    <= 1'b0;
      per_q   <= 1'b0;
      m32_q   <= 1'b0;
      route   <= '0;
      sv_q    <= SV_IDLE;
    end else if (cfg_wr) begin
      level_q <= wdata[CB_LEVEL];
      en_q    <= wdata[CB_EN];
      per_q   <= wdata[CB_PER];
      m32_q   <= wdata[CB_M32];
      route   <= wdata[CB_ROUTE +: RW];
      if (wdata[CB_SETV]) sv_q <= SV_MATCH;
    end else if (cmplo_wr) begin
      case (sv_q)
        SV_MATCH: sv_q <= SV_INCR;
        SV_INCR:  sv_q <= SV_IDLE;
        default:  sv_q <= SV_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp    <= '0;
      incr_q <= '0;
    end else begin
      if (match && per_q) begin
        if (m32_q) cmp[31:0] <= cmp[31:0] + incr_q;
        else       cmp       <= cmp + {32'd0, incr_q};
      end
      if (cmplo_wr) begin
        if (sv_q == SV_INCR) incr_q    <= wdata;
        else                 cmp[31:0] <= wdata;
      end
      if (cmphi_wr) cmp[63:32] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= match;
      if (match)    status <= 1'b1;
      else if (clr) status <= 1'b0;
    end
  end

  assign enabled = en_q;
  assign irq_raw = en_q & (level_q ? status : pulse_q);
  assign cfg_rd  = {{(32 - CB_ROUTE - RW){1'b0}}, route, m32_q, 1'b0, per_q, en_q, level_q};
endmodule

// File: rtl/evtimer_router.sv
module evtimer_router #(
  parameter int NUM_CH  = 4,
  parameter int NUM_IRQ = 8,
  parameter int RW      = 3
) (
  input  logic [NUM_CH-1:0]  ch_irq,
  input  logic [RW-1:0]      routes [NUM_CH],
  input  logic               legacy,
  output logic [NUM_IRQ-1:0] irq_o,
  output logic               leg_tick,
  output logic               leg_rtc
);
  always_comb begin
    irq_o = '0;
    for (int l = 0; l < NUM_IRQ; l++) begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (routes[n] == RW'(l) && !(legacy && n < 2) && ch_irq[n])
          irq_o[l] = 1'b1;
      end
    end
  end

  assign leg_tick = legacy & ch_irq[0];
  assign leg_rtc  = legacy & ch_irq[1];
endmodule

// File: rtl/evtimer_cmp.sv
module evtimer_cmp
  import evtimer_pkg::*;
#(
  parameter int          NUM_CH     = 4,
  parameter int          NUM_IRQ    = 8,
  parameter int          ADDR_W     = 12,
  parameter logic [31:0] PERIOD_FS  = 32'd69841279,
  parameter bit          LEGACY_CAP = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_IRQ-1:0] irq_o,
  output logic               legacy_tick_o,
  output logic               legacy_rtc_o
);
  localparam int RW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic        gctl_run_q, gctl_leg_q;
  logic [63:0] cnt_q;
  logic [11:0] addr12;
  logic        ch_region;
  logic [2:0]  ch_sel;
  logic [4:0]  ch_off;

  logic [NUM_CH-1:0] ch_status, ch_en, ch_irq, ch_clr;
  logic [31:0]       ch_cfg_rd [NUM_CH];
  logic [63:0]       ch_cmp    [NUM_CH];
  logic [RW-1:0]     ch_route  [NUM_CH];

  assign addr12    = 12'(bus_addr);
  assign ch_region = (addr12[11:8] == CH_REGION);
  assign ch_sel    = addr12[7:5];
  assign ch_off    = addr12[4:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctl_run_q <= 1'b0;
      gctl_leg_q <= 1'b0;
    end else if (bus_wr && addr12 == A_GCTL) begin
      gctl_run_q <= bus_wdata[GCTL_RUN];
      gctl_leg_q <= bus_wdata[GCTL_LEG] & LEGACY_CAP;
    end
  end

  evtimer_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (gctl_run_q),
    .wr_lo (bus_wr && addr12 == A_CNT_LO),
    .wr_hi (bus_wr && addr12 == A_CNT_HI),
    .wdata (bus_wdata),
    .cnt   (cnt_q)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic sel_n;
    assign sel_n     = bus_wr && ch_region && (ch_sel == 3'(n));
    assign ch_clr[n] = bus_wr && (addr12 == A_STAT) && bus_wdata[n];

    evtimer_channel #(.RW(RW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (sel_n && ch_off == OFF_CFG),
      .cmplo_wr (sel_n && ch_off == OFF_CMPLO),
      .cmphi_wr (sel_n && ch_off == OFF_CMPHI),
      .wdata    (bus_wdata),
      .cnt      (cnt_q),
      .run      (gctl_run_q),
      .clr      (ch_clr[n]),
      .cfg_rd   (ch_cfg_rd[n]),
      .cmp      (ch_cmp[n]),
      .route    (ch_route[n]),
      .enabled  (ch_en[n]),
      .status   (ch_status[n]),
      .irq_raw  (ch_irq[n])
    );
  end

  evtimer_router #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ), .RW(RW)) u_rt (
    .ch_irq   (ch_irq),
    .routes   (ch_route),
    .legacy   (gctl_leg_q),
    .irq_o    (irq_o),
    .leg_tick (legacy_tick_o),
    .leg_rtc  (legacy_rtc_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (addr12)
        A_ID:     bus_rdata = {16'd0, LEGACY_CAP, 2'b00, 5'(NUM_CH - 1), REVISION};
        A_PERIOD: bus_rdata = PERIOD_FS;
        A_GCTL:   bus_rdata = {30'd0, gctl_leg_q, gctl_run_q};
        A_STAT:   bus_rdata = 32'(ch_status);
        A_CNT_LO: bus_rdata = cnt_q[31:0];
        A_CNT_HI: bus_rdata = cnt_q[63:32];
        default: begin
          for (int n = 0; n < NUM_CH; n++) begin
            if (ch_region && ch_sel == 3'(n)) begin
              if (ch_off == OFF_CFG)   bus_rdata = ch_cfg_rd[n];
              if (ch_off == OFF_CMPLO) bus_rdata = ch_cmp[n][31:0];
              if (ch_off == OFF_CMPHI) bus_rdata = ch_cmp[n][63:32];
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/evtimer_sva.sv
module evtimer_sva #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [63:0]       cnt,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] status,
  input logic              legacy,
  input logic              leg_tick,
  input logic              leg_rtc
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cnt == $past(cnt) + 64'd1)); // R1

  AST_STATUS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(ch_en)) == '0)); // R4

  AST_TICK_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    leg_tick |-> (legacy && ch_en[0])); // R11

  AST_RTC_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    leg_rtc |-> (legacy && ch_en[1])); // R11
endmodule

bind evtimer_cmp evtimer_sva #(.NUM_CH(NUM_CH)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (gctl_run_q),
  .cnt      (cnt_q),
  .ch_en    (ch_en),
  .status   (ch_status),
  .legacy   (gctl_leg_q),
  .leg_tick (legacy_tick_o),
  .leg_rtc  (legacy_rtc_o)
);

// File: tb/evtimer_cmp_tb_top.sv
module evtimer_cmp_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_o;
  logic        legacy_tick_o, legacy_rtc_o;

  int checks = 0;
  int fails = 0;
  int pulses5 = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evtimer_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .legacy_tick_o(legacy_tick_o), .legacy_rtc_o(legacy_rtc_o)
  );

  always @(negedge clk) if (irq_o[5]) pulses5++;

  function automatic logic [11:0] cha(int n, int off);
    return 12'(32'h100 + 32'h20 * n + off);
  endfunction

  function automatic logic [31:0] cfgw(bit lvl, bit en, bit per, bit sv, bit m32, int rt);
    return (32'(rt) << 5) | (32'(m32) << 4) | (32'(sv) << 3) | (32'(per) << 2) | (32'(en) << 1) | 32'(lvl);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h000, v); check("R3 id", v, 32'h8301);
    rd(12'h004, v); check("R3 period", v, 32'd69841279);
    rd(12'h010, v); check("R3 gctl reset", v, 0);
    rd(12'h020, v); check("R3 status reset", v, 0);
    rd(12'h0F0, v); check("R3 counter reset", v, 0);
  endtask

  task automatic t_counter();
    logic [31:0] v;
    wr(12'h0F0, 32'd100); wr(12'h0F4, 0);
    rd(12'h0F0, v); check("R2 halted write", v, 100);
    wr(12'h010, 1);
    repeat (10) @(negedge clk);
    rd(12'h0F0, v); check("R1 count step", v, 110);
    wr(12'h0F0, 32'd5);
    rd(12'h0F0, v); check("R2 write ignored while running", v, 111);
    wr(12'h010, 0);
    rd(12'h0F0, v); check("R1 stop value", v, 112);
    repeat (5) @(negedge clk);
    rd(12'h0F0, v); check("R1 hold while halted", v, 112);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(12'h0F0, 0); wr(12'h0F4, 0);
    wr(cha(0,0), cfgw(1,1,0,0,0,0)); wr(cha(0,8), 20); wr(cha(0,12), 0);
    wr(cha(1,0), cfgw(1,1,0,0,0,1)); wr(cha(1,8), 20); wr(cha(1,12), 1);
    wr(cha(2,0), cfgw(1,1,0,0,1,2)); wr(cha(2,8), 20); wr(cha(2,12), 1);
    wr(cha(3,0), cfgw(1,0,0,0,0,3)); wr(cha(3,8), 20); wr(cha(3,12), 0);
    wr(12'h020, 32'hF);
    wr(12'h010, 1);
    repeat (30) @(negedge clk);
    wr(12'h010, 0);
    rd(12'h020, v); check("R4 64/32-bit match and enable gating", v, 32'h5);
    rd(cha(0,8), v); check("R5 one-shot comparator kept", v, 20);
    check("R9 R10 level lines", irq_o, 8'h05);
    wr(12'h020, 32'h1);
    rd(12'h020, v); check("R8 write-one clears", v, 32'h4);
    check("R9 level drops after clear", irq_o, 8'h04);
    wr(12'h020, 32'h0);
    rd(12'h020, v); check("R8 write-zero no effect", v, 32'h4);
    rd(cha(2,8), v); check("R12 comparator low kept", v, 20);
    rd(cha(2,12), v); check("R12 comparator high kept", v, 1);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(12'h0F0, 0); wr(12'h0F4, 0);
    wr(cha(1,0), cfgw(0,1,1,1,0,5));
    wr(cha(1,8), 10);
    wr(cha(1,8), 7);
    wr(cha(1,12), 0);
    rd(cha(1,0), v); check("R7 set-value reads zero", v, 32'hA6);
    rd(cha(1,8), v); check("R7 first write is match value", v, 10);
    wr(12'h020, 32'hF);
    pulses5 = 0;
    wr(12'h010, 1);
    repeat (42) @(negedge clk);
    wr(12'h010, 0);
    rd(cha(1,8), v); check("R6 periodic reload", v, 45);
    check("R9 R10 pulse count on line 5", 64'(pulses5), 5);
    wr(cha(1,8), 100);
    rd(cha(1,8), v); check("R7 third write loads comparator", v, 100);
    wr(12'h0F0, 95);
    wr(12'h010, 1);
    repeat (10) @(negedge clk);
    wr(12'h010, 0);
    rd(cha(1,8), v); check("R7 increment kept after sequence", v, 107);
  endtask

  task automatic t_legacy();
    logic [31:0] v;
    wr(12'h0F0, 0); wr(12'h0F4, 0);
    wr(cha(0,0), cfgw(1,1,0,0,0,4)); wr(cha(0,8), 5); wr(cha(0,12), 0);
    wr(cha(1,0), cfgw(1,1,0,0,0,4)); wr(cha(1,8), 6); wr(cha(1,12), 0);
    wr(cha(2,0), cfgw(1,0,0,0,0,2));
    wr(12'h020, 32'hF);
    wr(12'h010, 3);
    repeat (10) @(negedge clk);
    wr(12'h010, 2);
    #1;
    check("R11 legacy tick", legacy_tick_o, 1);
    check("R11 legacy rtc", legacy_rtc_o, 1);
    check("R11 routed line released", irq_o[4], 0);
    wr(12'h010, 0);
    #1;
    check("R11 legacy tick off", legacy_tick_o, 0);
    check("R11 legacy rtc off", legacy_rtc_o, 0);
    check("R10 routed line back", irq_o[4], 1);
    rd(cha(1,8), v); check("R12 comparator after halt", v, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_counter();
    t_oneshot();
    t_periodic();
    t_legacy();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule